// File: doc/BRIEF.md
# Software Interrupt Dispatcher

The dispatcher keeps the pending state of sixteen software interrupts for each of up to eight processors. Any processor can post a request word. The word names an interrupt number and picks a set of target processors through a two-bit filter. For every target, the dispatcher records which processor asked, so each (interrupt, target) pair holds a bitmap of source processors and a pending flag.

A target processor consumes requests one source at a time through an acknowledge flow. The dispatcher returns the interrupt number together with the lowest-numbered source still recorded, then removes that source. The pending flag drops only when the last source is gone. Byte-wide set and clear writes let a processor edit its own source bitmaps directly. Choosing which pending interrupt to take is left to a separate priority stage.

Acknowledge is the only flow with back-pressure. An acknowledge is taken when `ack_valid` and `ack_ready` are both high. `ack_ready` is high when the response slot is empty or is being drained in that cycle. A response stays valid and unchanged until `rsp_ready` is seen high. Request and bitmap writes are single-cycle strobes that are always taken.

Top module: `sgi_dispatch`

## Requirements
- R1: A request word with filter bits [25:24] = 0 targets each processor c whose bit [16+c] is set. The interrupt number is in bits [3:0]. Each target's bitmap for that number gains the bit of `req_cpu`, and `pend_flags[id*NCPU+c]` goes high one cycle later.
- R2: Filter value 1 targets every processor except `req_cpu`.
- R3: Filter value 2 targets only `req_cpu`. Filter value 3 changes no state.
- R4: An accepted acknowledge for (`ack_cpu`, `ack_id`) with a non-empty bitmap returns a response word. Bits [3:0] carry the id, bits [12:10] carry the lowest recorded source, bits [9:4] are zero, and `rsp_err` is 0. That source is then removed.
- R5: The pending flag stays high while any source remains and clears on the acknowledge that removes the last one.
- R6: An acknowledge on an empty bitmap returns `rsp_err`=1 with the source field 0 and changes no pending flag or bitmap.
- R7: A write with `bm_set`=1 ORs `bm_bits[NCPU-1:0]` into the bitmap of (`bm_id`, `bm_cpu`) and sets its flag, even when no bit is written. Bits at or above NCPU are ignored.
- R8: A write with `bm_set`=0 removes the written bits and clears the flag when the bitmap ends empty.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `ack_ready` is low.
- R10: An acknowledge reads the bitmap as it stood before the cycle. In a cycle with several updates, set operations land after clear operations, so a bit both cleared and set ends set.
- R11: After reset all pending flags are 0, `rsp_valid` is 0 and `ack_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request word strobe |
| req_cpu | input | CW | Processor posting the request |
| req_word | input | 32 | Request word: id, target list, filter |
| bm_wr | input | 1 | Bitmap write strobe |
| bm_set | input | 1 | 1 = set bits, 0 = clear bits |
| bm_cpu | input | CW | Processor whose bitmap is written |
| bm_id | input | 4 | Interrupt number of the bitmap write |
| bm_bits | input | 8 | Source bits written |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be taken |
| ack_cpu | input | CW | Acknowledging processor |
| ack_id | input | 4 | Interrupt number acknowledged |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 13 | id [3:0], source [12:10] |
| rsp_err | output | 1 | Acknowledge found an empty bitmap |
| pend_flags | output | 16*NCPU | Pending flag of id i for processor c at i*NCPU+c |

## Verification
An acknowledge can fall in the same cycle as a request word or a bitmap write aimed at the same (interrupt, processor) pair. The bench drives both strobes in one cycle. In the first case it checks that an acknowledge on an empty bitmap reports an error while the concurrent request still records its source. In the second it checks that a source being acknowledged and re-set in the same cycle stays recorded and is returned again by the next acknowledge.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SGI_IDS   = 16;
  localparam int ID_W      = 4;
  localparam int RSP_W     = 13;
  localparam int SRC_F_W   = 3;
  localparam int FILT_LSB  = 24;
  localparam int LIST_LSB  = 16;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_NONE   = 2'd3
  } filt_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [31:0]     req_word,
  input  logic [CW-1:0]   req_cpu,
  output logic [NCPU-1:0] tgt_mask,
  output logic            tgt_ok
);
  logic [NCPU-1:0] self_bit;
  filt_e           mode;

  always_comb begin
    for (int k = 0; k < NCPU; k++) self_bit[k] = (req_cpu == CW'(k));
    mode     = filt_e'(req_word[FILT_LSB +: 2]);
    tgt_ok   = (mode != FLT_NONE) && (|self_bit);
    unique case (mode)
      FLT_LIST:   tgt_mask = req_word[LIST_LSB +: NCPU];
      FLT_OTHERS: tgt_mask = ~self_bit;
      FLT_SELF:   tgt_mask = self_bit;
      default:    tgt_mask = '0;
    endcase
  end
endmodule

// File: rtl/sgi_low_pick.sv
module sgi_low_pick #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          empty
);
  always_comb begin
    idx = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) idx = IW'(k);
    end
    empty = ~|vec;
  end
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] set_mask,
  input  logic [NCPU-1:0] clr_mask,
  input  logic            set_flag,
  input  logic            touch,
  output logic [NCPU-1:0] src_map,
  output logic            pend
);
  logic [NCPU-1:0] map_n;

  always_comb map_n = (src_map & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_map <= '0;
      pend    <= 1'b0;
    end else begin
      src_map <= map_n;
      if (set_flag)                 pend <= 1'b1;
      else if (touch && map_n == '0) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_wr,
  input  logic [CW-1:0]           req_cpu,
  input  logic [31:0]             req_word,
  input  logic                    bm_wr,
  input  logic                    bm_set,
  input  logic [CW-1:0]           bm_cpu,
  input  logic [3:0]              bm_id,
  input  logic [7:0]              bm_bits,
  input  logic                    ack_valid,
  output logic                    ack_ready,
  input  logic [CW-1:0]           ack_cpu,
  input  logic [3:0]              ack_id,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [12:0]             rsp_data,
  output logic                    rsp_err,
  output logic [16*NCPU-1:0]      pend_flags
);
  localparam int NFLAG = SGI_IDS * NCPU;

  logic [NCPU-1:0] tgt_mask;
  logic            tgt_ok;
  logic            req_go;
  logic [NCPU-1:0] req_bit;
  logic [ID_W-1:0] req_id;

  logic [NCPU-1:0] map_a  [SGI_IDS][NCPU];
  logic            pend_a [SGI_IDS][NCPU];

  logic [NCPU-1:0] sel_map;
  logic [CW-1:0]   pick_idx;
  logic            ack_empty;
  logic            ack_fire;
  logic [NCPU-1:0] ack_clr;
  logic [NCPU-1:0] bm_mask;

  sgi_target_decode #(.NCPU(NCPU)) u_dec (
    .req_word (req_word),
    .req_cpu  (req_cpu),
    .tgt_mask (tgt_mask),
    .tgt_ok   (tgt_ok)
  );

  always_comb begin
    req_go  = req_wr && tgt_ok;
    req_id  = req_word[ID_W-1:0];
    req_bit = NCPU'(1) << req_cpu;
    bm_mask = bm_bits[NCPU-1:0];
    sel_map = '0;
    for (int k = 0; k < NCPU; k++) begin
      if (ack_cpu == CW'(k)) sel_map = map_a[ack_id][k];
    end
    ack_ready = !rsp_valid || rsp_ready;
    ack_fire  = ack_valid && ack_ready;
    ack_clr   = NCPU'(1) << pick_idx;
  end

  sgi_low_pick #(.W(NCPU), .IW(CW)) u_pick (
    .vec   (sel_map),
    .idx   (pick_idx),
    .empty (ack_empty)
  );

  for (genvar gi = 0; gi < SGI_IDS; gi++) begin : g_id
    for (genvar gc = 0; gc < NCPU; gc++) begin : g_cpu
      logic [NCPU-1:0] s_mask, c_mask;
      logic            s_flag, tch;

      always_comb begin
        s_mask = '0;
        c_mask = '0;
        s_flag = 1'b0;
        tch    = 1'b0;
        if (req_go && tgt_mask[gc] && req_id == ID_W'(gi)) begin
          s_mask = s_mask | req_bit;
          s_flag = 1'b1;
        end
        if (bm_wr && bm_cpu == CW'(gc) && bm_id == ID_W'(gi)) begin
          if (bm_set) begin
            s_mask = s_mask | bm_mask;
            s_flag = 1'b1;
          end else begin
            c_mask = c_mask | bm_mask;
            tch    = 1'b1;
          end
        end
        if (ack_fire && !ack_empty && ack_cpu == CW'(gc) && ack_id == ID_W'(gi)) begin
          c_mask = c_mask | ack_clr;
          tch    = 1'b1;
        end
      end

      sgi_cell #(.NCPU(NCPU)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (s_mask),
        .clr_mask (c_mask),
        .set_flag (s_flag),
        .touch    (tch),
        .src_map  (map_a[gi][gc]),
        .pend     (pend_a[gi][gc])
      );

      assign pend_flags[gi*NCPU + gc] = pend_a[gi][gc];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (ack_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= {(ack_empty ? 3'd0 : 3'(pick_idx)), 6'd0, ack_id};
      rsp_err   <= ack_empty;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, bm_bits, NFLAG[0]};
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_wr,
  input logic [31:0]         req_word,
  input logic                bm_wr,
  input logic                ack_valid,
  input logic                ack_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [12:0]         rsp_data,
  input logic                rsp_err,
  input logic [16*NCPU-1:0]  pend_flags
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err)); // R9

  AST_ACK_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> rsp_valid); // R4

  AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(rsp_data[12:10]) < NCPU) && rsp_data[9:4] == 6'd0); // R4

  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err && $past(ack_valid && ack_ready) && !$past(req_wr) && !$past(bm_wr)
    |-> pend_flags == $past(pend_flags)); // R6

  AST_BAD_FILTER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && req_word[25:24] == 2'd3 && !bm_wr && !(ack_valid && ack_ready)
    |=> $stable(pend_flags)); // R3
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_wr     (req_wr),
  .req_word   (req_word),
  .bm_wr      (bm_wr),
  .ack_valid  (ack_valid),
  .ack_ready  (ack_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_err    (rsp_err),
  .pend_flags (pend_flags)
);

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;
  localparam int NCPU = 4;
  localparam int CW   = 2;
  localparam int VW   = 115;
  localparam int NV   = 19;

  // op, cpu, word, exp_rsp, exp_err, exp_flags
  // op: 0 request, 1 set, 2 clear, 3 acknowledge; set/clear word: id [3:0], bits [15:8]
  localparam logic [VW-1:0] VECS [NV] = '{
    {2'd0, 3'd1, 32'h0005_0005, 13'h000, 1'b0, 64'h0000_0000_0050_0000},
    {2'd0, 3'd3, 32'h0100_0005, 13'h000, 1'b0, 64'h0000_0000_0070_0000},
    {2'd0, 3'd2, 32'h0200_0009, 13'h000, 1'b0, 64'h0000_0040_0070_0000},
    {2'd0, 3'd0, 32'h03FF_0001, 13'h000, 1'b0, 64'h0000_0040_0070_0000},
    {2'd3, 3'd0, 32'h0000_0005, 13'h405, 1'b0, 64'h0000_0040_0070_0000},
    {2'd3, 3'd0, 32'h0000_0005, 13'hC05, 1'b0, 64'h0000_0040_0060_0000},
    {2'd3, 3'd0, 32'h0000_0005, 13'h005, 1'b1, 64'h0000_0040_0060_0000},
    {2'd1, 3'd1, 32'h0000_0A07, 13'h000, 1'b0, 64'h0000_0040_2060_0000},
    {2'd2, 3'd1, 32'h0000_0207, 13'h000, 1'b0, 64'h0000_0040_2060_0000},
    {2'd3, 3'd1, 32'h0000_0007, 13'hC07, 1'b0, 64'h0000_0040_0060_0000},
    {2'd1, 3'd3, 32'h0000_0000, 13'h000, 1'b0, 64'h0000_0040_0060_0008},
    {2'd3, 3'd3, 32'h0000_0000, 13'h000, 1'b1, 64'h0000_0040_0060_0008},
    {2'd2, 3'd3, 32'h0000_0000, 13'h000, 1'b0, 64'h0000_0040_0060_0000},
    {2'd1, 3'd2, 32'h0000_F009, 13'h000, 1'b0, 64'h0000_0040_0060_0000},
    {2'd3, 3'd2, 32'h0000_0009, 13'h809, 1'b0, 64'h0000_0000_0060_0000},
    {2'd3, 3'd2, 32'h0000_0009, 13'h009, 1'b1, 64'h0000_0000_0060_0000},
    {2'd2, 3'd1, 32'h0000_0805, 13'h000, 1'b0, 64'h0000_0000_0040_0000},
    {2'd3, 3'd2, 32'h0000_0005, 13'h405, 1'b0, 64'h0000_0000_0040_0000},
    {2'd3, 3'd2, 32'h0000_0005, 13'hC05, 1'b0, 64'h0000_0000_0000_0000}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_wr = 1'b0;
  logic [CW-1:0]   req_cpu = '0;
  logic [31:0]     req_word = '0;
  logic            bm_wr = 1'b0;
  logic            bm_set = 1'b0;
  logic [CW-1:0]   bm_cpu = '0;
  logic [3:0]      bm_id = '0;
  logic [7:0]      bm_bits = '0;
  logic            ack_valid = 1'b0;
  logic            ack_ready;
  logic [CW-1:0]   ack_cpu = '0;
  logic [3:0]      ack_id = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [12:0]     rsp_data;
  logic            rsp_err;
  logic [63:0]     pend_flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sgi_dispatch #(.NCPU(NCPU)) i_sgi_dispatch (
    .clk(clk), .rst_n(rst_n),
    .req_wr(req_wr), .req_cpu(req_cpu), .req_word(req_word),
    .bm_wr(bm_wr), .bm_set(bm_set), .bm_cpu(bm_cpu), .bm_id(bm_id), .bm_bits(bm_bits),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .pend_flags(pend_flags)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic clear_in();
    req_wr = 1'b0; bm_wr = 1'b0; ack_valid = 1'b0;
  endtask

  task automatic apply(input logic [1:0] op, input logic [2:0] cpu, input logic [31:0] w);
    case (op)
      2'd0: begin req_wr = 1'b1; req_cpu = cpu[CW-1:0]; req_word = w; end
      2'd1, 2'd2: begin
        bm_wr = 1'b1; bm_set = (op == 2'd1); bm_cpu = cpu[CW-1:0];
        bm_id = w[3:0]; bm_bits = w[15:8];
      end
      default: begin ack_valid = 1'b1; ack_cpu = cpu[CW-1:0]; ack_id = w[3:0]; end
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 flags", pend_flags, 64'h0);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R11 ack_ready", 64'(ack_ready), 64'h1);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VECS[v];
      apply(e[114:113], e[112:110], e[109:78]);
      @(negedge clk);
      clear_in();
      case (e[114:113])
        2'd0: chk("R1 R2 R3 request flags", pend_flags, e[63:0]);
        2'd1: chk("R7 set flags", pend_flags, e[63:0]);
        2'd2: chk("R8 clear flags", pend_flags, e[63:0]);
        default: begin
          chk("R4 R6 ack rsp_valid", 64'(rsp_valid), 64'h1);
          chk("R4 R6 ack rsp_data", 64'(rsp_data), 64'(e[77:65]));
          chk("R6 ack rsp_err", 64'(rsp_err), 64'(e[64]));
          chk("R5 ack flags", pend_flags, e[63:0]);
        end
      endcase
    end

    // R9 back-pressure: id3 cpu0 holds sources {0,2}
    apply(2'd0, 3'd0, 32'h0200_0003);
    @(negedge clk); clear_in();
    apply(2'd1, 3'd0, 32'h0000_0403);
    @(negedge clk); clear_in();
    rsp_ready = 1'b0;
    apply(2'd3, 3'd0, 32'h0000_0003);
    @(negedge clk);
    chk("R9 first rsp", 64'(rsp_data), 64'h003);
    for (int k = 0; k < 3; k++) begin
      chk("R9 ack_ready low", 64'(ack_ready), 64'h0);
      @(negedge clk);
      chk("R9 rsp held", {rsp_valid, rsp_err, rsp_data}, {1'b1, 1'b0, 13'h003});
    end
    chk("R9 flag kept", 64'(pend_flags[12]), 64'h1);
    rsp_ready = 1'b1;
    @(negedge clk); clear_in();
    chk("R9 second rsp", {rsp_valid, rsp_err, rsp_data}, {1'b1, 1'b0, 13'h803});
    chk("R5 flag drops", 64'(pend_flags[12]), 64'h0);

    // R10 ack on empty map in the same cycle as a request from cpu1 to cpu0
    apply(2'd0, 3'd1, 32'h0001_0003);
    apply(2'd3, 3'd0, 32'h0000_0003);
    @(negedge clk); clear_in();
    chk("R10 ack sees old map", {rsp_err, rsp_data}, {1'b1, 13'h003});
    chk("R10 request lands", 64'(pend_flags[12]), 64'h1);
    // R10 ack removes src1 while a set write re-adds it
    apply(2'd1, 3'd0, 32'h0000_0203);
    apply(2'd3, 3'd0, 32'h0000_0003);
    @(negedge clk); clear_in();
    chk("R10 ack result", {rsp_err, rsp_data}, {1'b0, 13'h403});
    chk("R10 flag kept", 64'(pend_flags[12]), 64'h1);
    apply(2'd3, 3'd0, 32'h0000_0003);
    @(negedge clk); clear_in();
    chk("R10 set wins", {rsp_err, rsp_data}, {1'b0, 13'h403});
    chk("R5 last source", 64'(pend_flags[12]), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule